// File: doc/BRIEF.md
# Power-Down Mode Unlock Sequence Detector

This block sits beside the access port of a pseudo-static RAM. It watches every read and write strobe and recognises a six-access unlock pattern that reprograms the power-down mode. The pattern is aimed at the highest word address. A read captures the stored word, two writes return that same word, and two more writes carry data that is not used. A final read then selects the mode through its address alone, and no data takes part in that choice.

A separate active-low select input requests power-down. While that input is low, the block reports power-down as active and tells the array how far the retained range reaches. This depends on the mode that was programmed last. After reset the mode is the full-sleep one, in which nothing is retained, so no programming is needed to start.

For every write strobe, a commit flag tells the array whether the write must land as an ordinary store. Writes that the pattern absorbs are not stored. Which aborted writes are still stored depends on the step at which the pattern broke.

Top module: `pd_seq_detector`

## Requirements
- R1: After reset, mode_o is 0 (sleep), pd_active_o is 0, retain_en_o is 0 and retain_limit_o is 0.
- R2: The accesses read, write, write, write, write, read, all at 1FFFFFh, with both of the first two writes carrying the data returned by the first read, set mode_o to 0 (sleep) at the clock edge of the sixth access.
- R3: The same pattern with the sixth read at 17FFFFh (bit 19 clear, all other bits set) sets mode_o to 1 (partial) at the clock edge of the sixth access.
- R4: A second or third access that is a write to another address, or that writes data other than the captured word, aborts the pattern. commit_wr_o is 1 during that write.
- R5: A fourth or fifth access that is a write to another address aborts the pattern, and commit_wr_o is 0 during that write. The data of the fourth and fifth writes has no effect on the result.
- R6: A sixth read whose address matches neither key aborts the pattern and leaves mode_o unchanged.
- R7: A write where a read is expected returns the detector to idle. A read where a write is expected returns it to idle too, unless that read is at 1FFFFFh, in which case it counts as the first access of a new pattern.
- R8: One cycle after sel_n_i is sampled low, pd_active_o is 1. retain_en_o is then 1 only in partial mode, and retain_limit_o is 7FFFFh in partial mode and 0 otherwise. All three return to 0 one cycle after sel_n_i is sampled high.
- R9: Strobes sampled while sel_n_i is low are ignored: commit_wr_o stays 0, the pattern is aborted, and mode_o does not change.
- R10: commit_wr_o is 1 for writes outside any pattern and 0 for writes that the pattern absorbs. It is never 1 without a write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | One-cycle strobe per access |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_addr_i | input | 21 | Word address of the access |
| wr_data_i | input | 16 | Write data |
| rd_data_i | input | 16 | Data returned by the array for a read |
| sel_n_i | input | 1 | Power-down request, active low |
| mode_o | output | 1 | Programmed mode: 0 sleep, 1 partial |
| pd_active_o | output | 1 | Power-down in effect (registered) |
| retain_en_o | output | 1 | Lower range kept alive during power-down |
| retain_limit_o | output | 21 | Highest retained address, 0 when nothing is retained |
| commit_wr_o | output | 1 | The current write must be stored as an ordinary write |

## Verification
The bench builds the block with its default parameters: a 21-bit address, 16-bit data and bit 19 as the key bit. These values give the exact top address and partial key. They also allow near-miss keys such as 0FFFFFh (bit 20 clear), which must not be confused with either key. With 16-bit data, a write-back that differs from the captured word by a single bit becomes a reachable abort case. A behavioural model that steps through the pattern runs beside the design and is compared with it on every cycle while directed patterns break the sequence at each of the six steps.

// File: rtl/pd_seq_pkg.sv
package pd_seq_pkg;
  typedef enum logic {PD_SLEEP = 1'b0, PD_PARTIAL = 1'b1} pd_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_W2   = 3'd1,
    ST_W3   = 3'd2,
    ST_W4   = 3'd3,
    ST_W5   = 3'd4,
    ST_R6   = 3'd5
  } seq_st_e;

  typedef struct packed {
    logic top;
    logic key_partial;
  } addr_hit_t;
endpackage

// File: rtl/pd_addr_match.sv
module pd_addr_match
  import pd_seq_pkg::*;
#(
  parameter int ADDR_W  = 21,
  parameter int KEY_BIT = 19
) (
  input  logic [ADDR_W-1:0] addr_i,
  output addr_hit_t         hit_o
);
  localparam logic [ADDR_W-1:0] TOP_ADDR = '1;
  localparam logic [ADDR_W-1:0] PART_KEY = TOP_ADDR & ~(ADDR_W'(1) << KEY_BIT);

  always_comb begin
    hit_o.top         = (addr_i == TOP_ADDR);
    hit_o.key_partial = (addr_i == PART_KEY);
  end
endmodule

// File: rtl/pd_seq_fsm.sv
module pd_seq_fsm
  import pd_seq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  input  logic              acc_write_i,
  input  addr_hit_t         hit_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              sel_n_i,
  output logic              commit_o,
  output logic              set_sleep_o,
  output logic              set_partial_o
);
  seq_st_e           state_q, state_d;
  logic [DATA_W-1:0] cap_q, cap_d;
  logic              is_rd, is_wr;

  assign is_rd = acc_valid_i & sel_n_i & ~acc_write_i;
  assign is_wr = acc_valid_i & sel_n_i & acc_write_i;

  always_comb begin
    state_d       = state_q;
    cap_d         = cap_q;
    commit_o      = 1'b0;
    set_sleep_o   = 1'b0;
    set_partial_o = 1'b0;
    if (!sel_n_i) begin
      state_d = ST_IDLE;
    end else if (is_wr) begin
      unique case (state_q)
        ST_W2, ST_W3: begin
          if (hit_i.top && wr_data_i == cap_q) begin
            state_d = (state_q == ST_W2) ? ST_W3 : ST_W4;
          end else begin
            state_d  = ST_IDLE;
            commit_o = 1'b1;  // aborted write-back lands normally
          end
        end
        ST_W4: state_d = hit_i.top ? ST_W5 : ST_IDLE;  // aborted write dropped
        ST_W5: state_d = hit_i.top ? ST_R6 : ST_IDLE;
        default: begin
          state_d  = ST_IDLE;
          commit_o = 1'b1;
        end
      endcase
    end else if (is_rd) begin
      if (state_q == ST_R6) begin
        set_sleep_o   = hit_i.top;
        set_partial_o = hit_i.key_partial;
        state_d       = ST_IDLE;
      end else if (hit_i.top) begin
        state_d = ST_W2;  // any top read restarts the pattern
        cap_d   = rd_data_i;
      end else begin
        state_d = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cap_q   <= '0;
    end else begin
      state_q <= state_d;
      cap_q   <= cap_d;
    end
  end

  a_r9_pd_aborts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_n_i |=> state_q == ST_IDLE);
  a_r9_pd_no_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_n_i |-> !commit_o);
  a_r10_commit_needs_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> acc_valid_i && acc_write_i);
  a_r4_w3_bad_addr_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_W3 && is_wr && !hit_i.top) |=> state_q == ST_IDLE);
  a_r5_late_write_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_W4 || state_q == ST_W5) && is_wr) |-> !commit_o);
  a_r3_single_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({set_sleep_o, set_partial_o}));
  a_r7_key_only_after_five: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_sleep_o || set_partial_o) |-> state_q == ST_R6);
endmodule

// File: rtl/pd_mode_ctrl.sv
module pd_mode_ctrl
  import pd_seq_pkg::*;
#(
  parameter int ADDR_W  = 21,
  parameter int KEY_BIT = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_sleep_i,
  input  logic              set_partial_i,
  input  logic              sel_n_i,
  output pd_mode_e          mode_o,
  output logic              pd_active_o,
  output logic              retain_en_o,
  output logic [ADDR_W-1:0] retain_limit_o
);
  localparam logic [ADDR_W-1:0] RETAIN_LIMIT = (ADDR_W'(1) << KEY_BIT) - ADDR_W'(1);

  pd_mode_e          mode_q;
  logic              pd_q, ret_q;
  logic [ADDR_W-1:0] lim_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= PD_SLEEP;
      pd_q   <= 1'b0;
      ret_q  <= 1'b0;
      lim_q  <= '0;
    end else begin
      if (set_sleep_i)        mode_q <= PD_SLEEP;
      else if (set_partial_i) mode_q <= PD_PARTIAL;
      pd_q  <= ~sel_n_i;
      ret_q <= ~sel_n_i & (mode_q == PD_PARTIAL);
      lim_q <= (~sel_n_i && mode_q == PD_PARTIAL) ? RETAIN_LIMIT : '0;
    end
  end

  assign mode_o         = mode_q;
  assign pd_active_o    = pd_q;
  assign retain_en_o    = ret_q;
  assign retain_limit_o = lim_q;

  a_r6_mode_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(set_sleep_i || set_partial_i) |=> $stable(mode_q));
  a_r8_pd_enter: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_n_i |=> pd_q);
  a_r8_pd_leave: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_n_i |=> !pd_q && !ret_q && lim_q == '0);
  a_r8_retain_partial_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_q |-> pd_q && mode_q == PD_PARTIAL);
endmodule

// File: rtl/pd_seq_detector.sv
module pd_seq_detector
  import pd_seq_pkg::*;
#(
  parameter int ADDR_W  = 21,
  parameter int DATA_W  = 16,
  parameter int KEY_BIT = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  input  logic              acc_write_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              sel_n_i,
  output logic              mode_o,
  output logic              pd_active_o,
  output logic              retain_en_o,
  output logic [ADDR_W-1:0] retain_limit_o,
  output logic              commit_wr_o
);
  addr_hit_t hit;
  logic      set_sleep, set_partial;
  pd_mode_e  mode;

  pd_addr_match #(.ADDR_W(ADDR_W), .KEY_BIT(KEY_BIT)) u_match (
    .addr_i (acc_addr_i),
    .hit_o  (hit)
  );

  pd_seq_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .acc_valid_i   (acc_valid_i),
    .acc_write_i   (acc_write_i),
    .hit_i         (hit),
    .wr_data_i     (wr_data_i),
    .rd_data_i     (rd_data_i),
    .sel_n_i       (sel_n_i),
    .commit_o      (commit_wr_o),
    .set_sleep_o   (set_sleep),
    .set_partial_o (set_partial)
  );

  pd_mode_ctrl #(.ADDR_W(ADDR_W), .KEY_BIT(KEY_BIT)) u_mode (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .set_sleep_i    (set_sleep),
    .set_partial_i  (set_partial),
    .sel_n_i        (sel_n_i),
    .mode_o         (mode),
    .pd_active_o    (pd_active_o),
    .retain_en_o    (retain_en_o),
    .retain_limit_o (retain_limit_o)
  );

  assign mode_o = mode;
endmodule

// File: tb/pd_seq_detector_tb.sv
module pd_seq_detector_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [20:0] TOP  = 21'h1FFFFF;
  localparam logic [20:0] PKEY = 21'h17FFFF;
  localparam logic [20:0] LIM  = 21'h07FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, wr = 1'b0, sel_n = 1'b1;
  logic [20:0] addr = '0;
  logic [15:0] wd = '0, rd = '0;
  logic        mode_o, pd_o, ret_o, commit_o;
  logic [20:0] lim_o;

  int    checks = 0, failures = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  // reference model state
  int       m_step = 0;
  logic [15:0] m_cap = '0;
  logic     m_mode = 1'b0, m_pd = 1'b0, m_ret = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pd_seq_detector u_dut (
    .clk_i(clk), .rst_ni(rst_n), .acc_valid_i(valid), .acc_write_i(wr),
    .acc_addr_i(addr), .wr_data_i(wd), .rd_data_i(rd), .sel_n_i(sel_n),
    .mode_o(mode_o), .pd_active_o(pd_o), .retain_en_o(ret_o),
    .retain_limit_o(lim_o), .commit_wr_o(commit_o)
  );

  function automatic void restart_on_read();
    if (addr == TOP) begin m_step = 1; m_cap = rd; end
    else m_step = 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_step = 0; m_cap = '0; m_mode = 1'b0; m_pd = 1'b0; m_ret = 1'b0;
    end else begin
      m_ret = !sel_n && m_mode;
      m_pd  = !sel_n;
      if (!sel_n) m_step = 0;
      else if (valid) begin
        case (m_step)
          0: if (!wr) restart_on_read();
          1, 2: if (wr) m_step = (addr == TOP && wd == m_cap) ? m_step + 1 : 0;
                else restart_on_read();
          3, 4: if (wr) m_step = (addr == TOP) ? m_step + 1 : 0;
                else restart_on_read();
          default: begin
            if (!wr) begin
              if (addr == TOP) m_mode = 1'b0;
              else if (addr == PKEY) m_mode = 1'b1;
            end
            m_step = 0;
          end
        endcase
      end
    end
  end

  function automatic logic exp_commit();
    if (!valid || !wr || !sel_n) return 1'b0;
    case (m_step)
      0, 5: return 1'b1;
      1, 2: return !(addr == TOP && wd == m_cap);
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", cur_req, what, act, exp, $time);
    end
  endtask

  always begin
    @(negedge clk); #2;
    if (rst_n && !done) begin
      chk("mode_o", 32'(mode_o), 32'(m_mode));
      chk("pd_active_o", 32'(pd_o), 32'(m_pd));
      chk("retain_en_o", 32'(ret_o), 32'(m_ret));
      chk("retain_limit_o", 32'(lim_o), m_ret ? 32'(LIM) : 32'd0);
      chk("commit_wr_o", 32'(commit_o), 32'(exp_commit()));
    end
  end

  task automatic acc(bit w, logic [20:0] a, logic [15:0] d);
    @(negedge clk);
    valid = 1'b1; wr = w; addr = a;
    if (w) wd = d; else rd = d;
    @(negedge clk);
    valid = 1'b0;
    @(negedge clk);  // standby between accesses
  endtask

  task automatic unlock(logic [15:0] d, logic [20:0] key);
    acc(0, TOP, d); acc(1, TOP, d); acc(1, TOP, d);
    acc(1, TOP, 16'h1234); acc(1, TOP, 16'hFEDC); acc(0, key, 16'h0);
  endtask

  task automatic power_down(int n);
    @(negedge clk); sel_n = 1'b0;
    repeat (n) @(negedge clk);
    sel_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    cur_req = "R1";
    chk("reset mode", 32'(mode_o), 32'd0);
    chk("reset pd", 32'(pd_o), 32'd0);
    chk("reset limit", 32'(lim_o), 32'd0);

    cur_req = "R8"; power_down(4);  // sleep: nothing retained
    cur_req = "R3"; unlock(16'hA5C3, PKEY);
    chk("partial set", 32'(mode_o), 32'd1);
    cur_req = "R8"; power_down(5);
    cur_req = "R2"; unlock(16'h3C5A, TOP);
    chk("sleep set", 32'(mode_o), 32'd0);

    cur_req = "R4";  // wrong address on second access
    acc(0, TOP, 16'h1111); acc(1, 21'h000123, 16'h1111);
    acc(1, TOP, 16'h1111); acc(1, TOP, 16'h1); acc(1, TOP, 16'h2); acc(0, PKEY, 0);
    chk("bad step2 keeps mode", 32'(mode_o), 32'd0);
    // wrong data on third access (single bit)
    acc(0, TOP, 16'h2222); acc(1, TOP, 16'h2222); acc(1, TOP, 16'h2223);
    acc(1, TOP, 16'h1); acc(1, TOP, 16'h2); acc(0, PKEY, 0);
    chk("bad step3 keeps mode", 32'(mode_o), 32'd0);

    cur_req = "R5";  // wrong address on fourth, then fifth
    acc(0, TOP, 16'h4444); acc(1, TOP, 16'h4444); acc(1, TOP, 16'h4444);
    acc(1, 21'h0FFFFF, 16'h0); acc(1, TOP, 16'h0); acc(0, PKEY, 0);
    chk("bad step4 keeps mode", 32'(mode_o), 32'd0);
    acc(0, TOP, 16'h5555); acc(1, TOP, 16'h5555); acc(1, TOP, 16'h5555);
    acc(1, TOP, 16'hFFFF); acc(1, 21'h1FFFFE, 16'h0); acc(0, PKEY, 0);
    chk("bad step5 keeps mode", 32'(mode_o), 32'd0);

    cur_req = "R6";  // near-miss key
    unlock(16'h6666, 21'h0FFFFF);
    chk("unmatched key", 32'(mode_o), 32'd0);
    unlock(16'h6767, PKEY);
    unlock(16'h6868, 21'h000000);
    chk("unmatched key keeps partial", 32'(mode_o), 32'd1);

    cur_req = "R7";  // write first, then top read restarting mid-pattern
    acc(1, TOP, 16'h7777);
    acc(0, TOP, 16'h7000); acc(1, TOP, 16'h7000);
    acc(0, 21'h000010, 16'h0);  // read where write expected: idle
    acc(1, TOP, 16'h7000); acc(1, TOP, 0); acc(1, TOP, 0); acc(0, TOP, 0);
    chk("non-top read aborts", 32'(mode_o), 32'd1);
    acc(0, TOP, 16'h7100); acc(1, TOP, 16'h7100);
    unlock(16'h7200, TOP);  // top read restarts the pattern
    chk("restart then sleep", 32'(mode_o), 32'd0);
    acc(0, TOP, 16'h7300); acc(1, TOP, 16'h7300); acc(1, TOP, 16'h7300);
    acc(1, TOP, 0); acc(1, TOP, 0); acc(1, PKEY, 0);  // write at key step
    chk("write at step6 ignored", 32'(mode_o), 32'd0);

    cur_req = "R9";  // pattern while select low
    @(negedge clk); sel_n = 1'b0;
    unlock(16'h9999, PKEY);
    acc(1, 21'h000055, 16'h5);
    @(negedge clk); sel_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("pd ignores pattern", 32'(mode_o), 32'd0);

    cur_req = "R10";
    acc(1, 21'h000100, 16'hAAAA); acc(0, 21'h000100, 16'hAAAA);
    unlock(16'hBEEF, PKEY);
    cur_req = "R8"; power_down(3);
    chk("exit clears pd", 32'(pd_o), 32'd0);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule